// File: doc/BRIEF.md
# Column Lane Reed-Solomon Encoder with Symbol Regrouping

This block is one per-chip lane of a two-dimensional Reed-Solomon segment encoder. Each row word from the row encoder contributes one 4-bit row symbol to this lane. The lane regroups those symbols into 6-bit column symbols as they arrive and forwards each column symbol unchanged toward the flash write interface. As each symbol passes, it is also folded into a Reed-Solomon parity register over GF(2^6).

A segment column holds 60 column symbols. The first 54 are data, carried by 81 row symbols, and the last 6 are parity. When the last row symbol of a segment has been taken in, the lane raises a pause request. It keeps the request high while it sends the six parity symbols, then drops it so the next segment can start. The last parity symbol is marked as the end of the segment.

Top module: `colenc_lane`

## Requirements
- R1: While reset is held and right after it, `col_valid`, `col_eos` and `pause_req` are 0.
- R2: Row symbols r0, r1, r2 arrive in that order, each aligned at a 12-bit group boundary. They produce the column symbol {r0, r1[3:2]} and then the column symbol {r1[1:0], r2}. Each column symbol is presented with `col_valid` in the cycle after the clock edge that accepts the row symbol completing it.
- R3: One segment takes 81 accepted row symbols and yields exactly 60 valid column symbols: 54 data symbols followed by 6 parity symbols.
- R4: The 60-symbol column, with the first symbol as the highest-degree coefficient, evaluates to zero at alpha^0 through alpha^5. Here alpha is a root of x^6+x+1, and each symbol bit 5 is the coefficient of alpha^5.
- R5: `pause_req` rises at the same edge that presents the last data symbol and stays high for exactly 6 cycles.
- R6: While `pause_req` is high, `row_valid` and `row_sym` are ignored. Symbols driven then appear in no later output.
- R7: `col_eos` is high only with the sixth parity symbol, and `pause_req` falls at that same edge.
- R8: Cycles with `row_valid` low produce no data output and leave the output values unchanged, whatever the spacing of the gaps.
- R9: Segments follow one another without reset. Each segment starts from cleared parity and packing state, so its parity depends only on its own data.
- R10: A reset in the middle of a segment discards the partial symbols and the parity, and the next segment is encoded from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid | input | 1 | Row symbol present |
| row_sym | input | 4 | Row symbol, most significant bit first in the column |
| pause_req | output | 1 | Upstream must hold off; row input ignored |
| col_valid | output | 1 | Column symbol present |
| col_sym | output | 6 | Column symbol (data or parity) |
| col_eos | output | 1 | Last symbol of the segment column |

## Verification
Segments are driven with all-zero data, all-ones data, an incrementing ramp, pseudo-random symbols and a single non-zero symbol. Zero data must give zero parity. The lone symbol isolates one generator column, and the random and ramp data exercise every regrouping phase against the codeword zero test. Runs with idle gaps and with garbage driven during the pause separate a stall-dependent or leaky input path from a correct one. A back-to-back pair and a mid-segment reset reveal parity or packing state that carries over from earlier input.

// File: rtl/colenc_pkg.sv
package colenc_pkg;
  localparam int COL_W = 6;
  localparam logic [COL_W:0] FIELD_POLY = 7'b1000011;  // x^6 + x + 1
  typedef logic [COL_W-1:0] csym_t;

  // Multiply two field elements, reducing modulo FIELD_POLY
  function automatic csym_t gf_mul(csym_t a, csym_t b);
    csym_t acc;
    csym_t aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < COL_W; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[COL_W-1] ? ((aa << 1) ^ FIELD_POLY[COL_W-1:0]) : (aa << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/colenc_regroup.sv
module colenc_regroup #(
  parameter int ROW_W = 4,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [ROW_W-1:0] row_in,
  output logic             emit,
  output logic [COL_W-1:0] col_out
);
  localparam int ACC_W = ROW_W + COL_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_d, acc_ext, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sum;

  // The register keeps fewer than COL_W pending bits, right-aligned
  always_comb begin
    acc_ext = {acc_q[ACC_W-ROW_W-1:0], row_in};
    cnt_sum = cnt_q + CNT_W'(ROW_W);
    emit    = take && (cnt_sum >= CNT_W'(COL_W));
    shifted = acc_ext >> (cnt_sum - CNT_W'(COL_W));
    col_out = shifted[COL_W-1:0];
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    if (take) begin
      acc_d = acc_ext;
      cnt_d = emit ? (cnt_sum - CNT_W'(COL_W)) : cnt_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/colenc_parity.sv
module colenc_parity
  import colenc_pkg::*;
#(
  parameter int NPAR = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  absorb,
  input  logic  drain,
  input  csym_t din,
  output csym_t par_top
);
  typedef logic [NPAR:0][COL_W-1:0] gpoly_t;

  // Product of (x + alpha^i) for i = 0 .. NPAR-1
  function automatic gpoly_t make_gen();
    gpoly_t g;
    csym_t  root;
    g    = '0;
    g[0] = csym_t'(1);
    root = csym_t'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int k = NPAR; k > 0; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, csym_t'(2));
    end
    return g;
  endfunction

  localparam gpoly_t GEN = make_gen();

  csym_t par_q [NPAR];
  csym_t par_d [NPAR];
  csym_t fb;

  assign fb      = din ^ par_q[NPAR-1];
  assign par_top = par_q[NPAR-1];

  generate
    for (genvar i = 0; i < NPAR; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb begin
          if (absorb)     par_d[i] = gf_mul(fb, GEN[i]);
          else if (drain) par_d[i] = '0;
          else            par_d[i] = par_q[i];
        end
      end else begin : g_rest
        always_comb begin
          if (absorb)     par_d[i] = par_q[i-1] ^ gf_mul(fb, GEN[i]);
          else if (drain) par_d[i] = par_q[i-1];
          else            par_d[i] = par_q[i];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                par_q[i] <= '0;
        else if (absorb || drain)  par_q[i] <= par_d[i];
      end
    end
  endgenerate
endmodule

// File: rtl/colenc_ctrl.sv
module colenc_ctrl #(
  parameter int DATA_ROWS = 81,
  parameter int NPAR      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_valid,
  output logic take,
  output logic in_par,
  output logic par_last
);
  localparam int RC_W = $clog2(DATA_ROWS + 1);
  localparam int PC_W = $clog2(NPAR + 1);

  typedef enum logic {ST_DATA, ST_PAR} phase_t;

  phase_t          st_q, st_d;
  logic [RC_W-1:0] row_q, row_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            last_row;

  assign in_par   = (st_q == ST_PAR);
  assign take     = row_valid && (st_q == ST_DATA);
  assign last_row = take && (row_q == RC_W'(DATA_ROWS - 1));
  assign par_last = in_par && (pc_q == PC_W'(NPAR - 1));

  always_comb begin
    st_d  = st_q;
    row_d = row_q;
    pc_d  = pc_q;
    if (st_q == ST_DATA) begin
      if (take) row_d = last_row ? '0 : row_q + 1'b1;
      if (last_row) begin
        st_d = ST_PAR;
        pc_d = '0;
      end
    end else begin
      pc_d = pc_q + 1'b1;
      if (par_last) st_d = ST_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_DATA;
      row_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      pc_q  <= pc_d;
    end
  end
endmodule

// File: rtl/colenc_lane.sv
module colenc_lane
  import colenc_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int SEG_SYMS = 60,
  parameter int PAR_SYMS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_valid,
  input  logic [ROW_W-1:0] row_sym,
  output logic             pause_req,
  output logic             col_valid,
  output logic [COL_W-1:0] col_sym,
  output logic             col_eos
);
  localparam int DATA_COLS = SEG_SYMS - PAR_SYMS;
  localparam int DATA_BITS = DATA_COLS * COL_W;
  localparam int DATA_ROWS = DATA_BITS / ROW_W;

  logic  take, in_par, par_last, emit;
  csym_t pk_sym, par_top;
  logic  nx_valid, nx_eos;
  csym_t nx_sym;

  colenc_ctrl #(.DATA_ROWS(DATA_ROWS), .NPAR(PAR_SYMS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid),
    .take(take), .in_par(in_par), .par_last(par_last)
  );

  colenc_regroup #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .row_in(row_sym),
    .emit(emit), .col_out(pk_sym)
  );

  colenc_parity #(.NPAR(PAR_SYMS)) u_par (
    .clk(clk), .rst_n(rst_n), .absorb(emit), .drain(in_par),
    .din(pk_sym), .par_top(par_top)
  );

  assign pause_req = in_par;

  always_comb begin
    nx_valid = emit || in_par;
    nx_sym   = in_par ? par_top : pk_sym;
    nx_eos   = par_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_eos   <= 1'b0;
      col_sym   <= '0;
    end else begin
      col_valid <= nx_valid;
      col_eos   <= nx_eos;
      if (nx_valid) col_sym <= nx_sym;
    end
  end
endmodule

// File: rtl/colenc_lane_chk.sv
module colenc_lane_chk #(
  parameter int SEG_SYMS = 60,
  parameter int PAR_SYMS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic row_valid,
  input logic pause_req,
  input logic col_valid,
  input logic col_eos
);
  int pause_run;
  int sym_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_run <= 0;
      sym_cnt   <= 0;
    end else begin
      pause_run <= pause_req ? pause_run + 1 : 0;
      if (col_valid) sym_cnt <= col_eos ? 0 : sym_cnt + 1;
    end
  end

  AST_EOS_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_eos |-> col_valid);  // R7
  AST_PAUSE_END_EOS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_req) |-> col_eos);  // R7
  AST_PAUSE_START_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> (col_valid && !col_eos));  // R5
  AST_PAUSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_req) |-> (pause_run == PAR_SYMS));  // R5
  AST_SEGMENT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    col_eos |-> (sym_cnt == SEG_SYMS - 1));  // R3
  AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_valid && !pause_req) |=> !col_valid);  // R8
endmodule

bind colenc_lane colenc_lane_chk #(.SEG_SYMS(SEG_SYMS), .PAR_SYMS(PAR_SYMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .pause_req(pause_req),
  .col_valid(col_valid), .col_eos(col_eos)
);

// File: tb/colenc_lane_test.sv
`timescale 1ns/1ps
module colenc_lane_test;
  localparam int NROW = 81;
  localparam int NSEG = 60;
  localparam int NDAT = 54;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       row_valid;
  logic [3:0] row_sym;
  logic       pause_req, col_valid, col_eos;
  logic [5:0] col_sym;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [5:0] cap_sym [0:127];
  logic       cap_eos [0:127];
  int         cap_n;
  int         pause_cycles;
  logic [3:0] rows [0:NROW-1];

  colenc_lane uut (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_sym(row_sym),
    .pause_req(pause_req), .col_valid(col_valid), .col_sym(col_sym),
    .col_eos(col_eos)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (col_valid && cap_n < 128) begin
        cap_sym[cap_n] = col_sym;
        cap_eos[cap_n] = col_eos;
        cap_n = cap_n + 1;
      end
      if (pause_req) pause_cycles = pause_cycles + 1;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] gmul(logic [5:0] a, logic [5:0] b);
    logic [11:0] p;
    p = '0;
    for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (12'(a) << i);
    for (int i = 11; i >= 6; i--) if (p[i]) p = p ^ (12'h043 << (i - 6));
    return p[5:0];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    row_valid = 1'b0;
    row_sym = '0;
    repeat (3) @(negedge clk);
    check(col_valid == 0 && col_eos == 0 && pause_req == 0, "R1 in reset",
          {col_valid, col_eos, pause_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_valid == 0 && col_eos == 0 && pause_req == 0, "R1 after reset",
          {col_valid, col_eos, pause_req}, 0);
  endtask

  task automatic fill_rows(input int pat, input int seed);
    int s;
    s = seed;
    for (int k = 0; k < NROW; k++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      case (pat)
        0: rows[k] = 4'h0;
        1: rows[k] = 4'(k);
        2: rows[k] = 4'hF;
        3: rows[k] = 4'(s >> 16);
        default: rows[k] = (k == 40) ? 4'h9 : 4'h0;
      endcase
    end
  endtask

  // Drive one segment; optional idle gaps and garbage during the pause
  task automatic drive_segment(input bit gaps, input bit garbage);
    int  k;
    bit  fin;
    k = 0;
    cap_n = 0;
    pause_cycles = 0;
    while (k < NROW) begin
      @(negedge clk);
      if (pause_req) begin
        row_valid = garbage;
        row_sym = 4'hA;
      end else if (gaps && (k % 7 == 3) && row_valid) begin
        row_valid = 1'b0;
      end else begin
        row_valid = 1'b1;
        row_sym = rows[k];
        k = k + 1;
      end
    end
    fin = 0;
    while (!fin) begin
      @(negedge clk);
      if (col_valid && col_eos) fin = 1;
      row_valid = garbage && pause_req;
      row_sym = 4'h6;
    end
    row_valid = 1'b0;
    #1;
  endtask

  task automatic verify_segment(input string tag);
    logic [NDAT*6-1:0] v;
    logic [5:0] s, root;
    int bad, eos_at;
    v = '0;
    for (int k = 0; k < NROW; k++) v[NDAT*6-1-4*k -: 4] = rows[k];
    check(cap_n == NSEG, {"R3 symbol count ", tag}, cap_n, NSEG);
    bad = -1;
    for (int j = 0; j < NDAT; j++)
      if (bad < 0 && cap_sym[j] !== v[NDAT*6-1-6*j -: 6]) bad = j;
    check(bad < 0, {"R2 data symbols ", tag}, bad, -1);
    root = 6'd1;
    for (int i = 0; i < 6; i++) begin
      s = '0;
      for (int j = 0; j < NSEG; j++) s = gmul(s, root) ^ cap_sym[j];
      check(s == 0, {"R4 syndrome ", tag}, s, 0);
      root = gmul(root, 6'd2);
    end
    eos_at = -1;
    for (int j = 0; j < NSEG; j++) if (cap_eos[j]) eos_at = (eos_at < 0) ? j : 999;
    check(eos_at == NSEG - 1, {"R7 eos position ", tag}, eos_at, NSEG - 1);
    check(pause_cycles == 6, {"R5 pause length ", tag}, pause_cycles, 6);
  endtask

  task automatic t_regroup_latency();
    cap_n = 0;
    @(negedge clk); row_valid = 1; row_sym = 4'hB;
    @(negedge clk); check(col_valid == 0, "R2 no output after first", col_valid, 0);
    row_sym = 4'h6;
    @(negedge clk);
    check(col_valid == 1 && col_sym == 6'b101101, "R2 first column symbol", col_sym, 6'b101101);
    row_valid = 0;
    @(negedge clk);
    check(col_valid == 0, "R8 gap gives no output", col_valid, 0);
    check(col_sym == 6'b101101, "R8 gap holds value", col_sym, 6'b101101);
    row_valid = 1; row_sym = 4'h3;
    @(negedge clk);
    check(col_valid == 1 && col_sym == 6'b100011, "R2 second column symbol", col_sym, 6'b100011);
    row_valid = 0;
  endtask

  task automatic t_mid_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_valid == 0 && pause_req == 0, "R10 clean after mid reset",
          {col_valid, pause_req}, 0);
    fill_rows(3, 77);
    drive_segment(0, 0);
    verify_segment("R10 after reset");
  endtask

  task automatic t_patterns();
    fill_rows(0, 0); drive_segment(0, 0); verify_segment("zero");
    check(cap_sym[54] == 0 && cap_sym[59] == 0, "R4 zero parity", cap_sym[54], 0);
    fill_rows(2, 0); drive_segment(0, 0); verify_segment("ones");
    fill_rows(1, 0); drive_segment(1, 0); verify_segment("ramp R8 gaps");
    fill_rows(4, 0); drive_segment(0, 0); verify_segment("single");
  endtask

  task automatic t_back_to_back();
    fill_rows(3, 5); drive_segment(0, 1); verify_segment("R6 garbage seg1");
    fill_rows(3, 9); drive_segment(0, 0); verify_segment("R9 R6 seg2");
    fill_rows(4, 0); drive_segment(1, 1); verify_segment("R9 seg3");
  endtask

  initial begin
    cap_n = 0;
    pause_cycles = 0;
    do_reset();
    t_regroup_latency();
    t_mid_reset();
    t_patterns();
    t_back_to_back();
    done = 1;
    summary();
  end
endmodule